// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDR SDRAM burst, one column per clock. A one-cycle start pulse captures the first column, a three-bit length code and an ordering bit. The block then walks through the burst. Fixed-length bursts stay inside an aligned block whose size is the burst length. The low column bits either count upward and wrap at the block edge, or are the starting offset XORed with a step counter. A row-length burst counts upward through the whole row, wraps at the row end, and runs until it is told to stop.

A companion strobe follows the issued columns after a read latency of two or three clocks, so a data path can capture read data without tracking the latency itself. A device model or a controller uses the block as the column half of its read and write engine. Bank, row, refresh and the data bus are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `col_vld_o`, `rd_vld_o` and `err_o` are 0.
- R2: Length code 3'b000 issues exactly one column, equal to the start column, and the ordering bit has no effect.
- R3: Length codes 3'b001, 3'b010 and 3'b011 issue 2, 4 and 8 columns. Every column keeps the start column's bits above the low 1, 2 or 3 bits.
- R4: With `ilv_i` = 0, the low bits of step i are (start offset + i) modulo the length. For example, a length-8 burst starting at offset 5 issues 5,6,7,0,1,2,3,4.
- R5: With `ilv_i` = 1 and a length of 2, 4 or 8, the low bits of step i are the start offset XOR i. For example, a length-8 burst starting at offset 5 issues 5,4,7,6,1,0,3,2.
- R6: Length code 3'b111 with `ilv_i` = 0 issues the start column and then increments through the full row of 2^COL_W columns, wrapping at the row end, until it is stopped.
- R7: `stop_i` high at a clock edge with no start pulse ends any active burst. `col_vld_o` is 0 after that edge.
- R8: A start pulse during an active burst abandons that burst. The new burst's first column appears after the same edge.
- R9: A start pulse with length code 3'b111 and `ilv_i` = 1 issues no column, ends any active burst, and drives `err_o` high for exactly one cycle.
- R10: The first column is on `col_o` with `col_vld_o` = 1 in the cycle after the edge that samples the start pulse. Later columns follow on consecutive cycles.
- R11: `rd_vld_o` equals `col_vld_o` delayed by 2 clocks when `cl3_i` = 0, and by 3 clocks when `cl3_i` = 1.
- R12: The reserved length codes 3'b100, 3'b101 and 3'b110 behave like code 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle burst start pulse |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 counts up, 1 uses XOR stepping |
| cl3_i | input | 1 | Read latency select: 0 gives 2 clocks, 1 gives 3 clocks |
| stop_i | input | 1 | Terminates the active burst |
| col_o | output | COL_W | Issued column address |
| col_vld_o | output | 1 | `col_o` holds a column this cycle |
| rd_vld_o | output | 1 | Latency-delayed copy of `col_vld_o` |
| err_o | output | 1 | One-cycle flag for a rejected start |

## Verification
The bench uses the default COL_W = 9. A row-length burst therefore spans only 512 columns, so a run that crosses the row end and comes back round the whole row fits in a few hundred cycles. MAX_CL stays at 3, which makes both latency settings reachable. This lets the bench compare the delayed strobe against the column stream after truncation by stop, by abort and by rejection.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Burst length codes; the numeric value of the fixed lengths is log2 of the length.
  typedef enum logic [2:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_ROW   = 3'd7
  } blen_e;

  localparam int unsigned MIN_CL = 2;

endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             single_o
);

  // Mask of the column bits that move within the burst.
  always_comb begin
    mask_o   = '0;
    full_o   = 1'b0;
    single_o = 1'b0;
    case (blen_e'(code_i))
      BL_TWO:   mask_o = COL_W'(1);
      BL_FOUR:  mask_o = COL_W'(3);
      BL_EIGHT: mask_o = COL_W'(7);
      BL_ROW: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:  single_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             single_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             err_o
);

  // Column at a given step: the bits outside the mask hold, the bits inside it step.
  function automatic logic [COL_W-1:0] col_at(
    input logic [COL_W-1:0] base,
    input logic [COL_W-1:0] mask,
    input logic             ilv,
    input logic [COL_W-1:0] step
  );
    logic [COL_W-1:0] off;
    logic [COL_W-1:0] low;
    off = base & mask;
    low = ilv ? (off ^ step) : ((off + step) & mask);
    return (base & ~mask) | (low & mask);
  endfunction

  logic [COL_W-1:0] base_q, mask_q, cnt_q, col_q;
  logic             ilv_q, full_q, vld_q, err_q;

  // Named internal events.
  logic             start_bad, start_go, burst_last, burst_halt;
  logic [COL_W-1:0] cnt_nxt;

  assign start_bad  = start_i & full_i & ilv_i;
  assign start_go   = start_i & ~start_bad;
  assign burst_last = vld_q & ~full_q & (cnt_q == mask_q);
  assign burst_halt = vld_q & (stop_i | burst_last);
  assign cnt_nxt    = cnt_q + COL_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
      col_q  <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= start_bad;
      if (start_go) begin
        base_q <= start_col_i;
        mask_q <= mask_i;
        ilv_q  <= ilv_i & ~single_i;
        full_q <= full_i;
        cnt_q  <= '0;
        col_q  <= start_col_i;
        vld_q  <= 1'b1;
      end else if (start_bad) begin
        vld_q <= 1'b0;
      end else if (burst_halt) begin
        vld_q <= 1'b0;
      end else if (vld_q) begin
        cnt_q <= cnt_nxt;
        col_q <= col_at(base_q, mask_q, ilv_q, cnt_nxt);
      end
    end
  end

  assign col_o     = col_q;
  assign col_vld_o = vld_q;
  assign err_o     = err_q;

  // R10: an accepted start shows its column on the next cycle
  assert_start_issues_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (vld_q && col_q == $past(start_col_i)));

  // R3: the bits above the moving field do not change within a fixed burst
  assert_block_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !full_q && !start_i && !stop_i && !burst_last)
      |=> (vld_q && ((col_q & ~mask_q) == ($past(col_q) & ~mask_q))));

  // R7: stop without a start ends the burst
  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !vld_q);

  // R9: a rejected start flags an error and issues nothing
  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (err_q && !vld_q));

  // R9: the error flag lasts one cycle unless another rejected start follows
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start_bad) |=> !err_q);

endmodule

// File: rtl/bcs_rd_delay.sv
module bcs_rd_delay
  import bcs_pkg::*;
#(
  parameter int unsigned MAX_CL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  logic cl3_i,
  output logic rd_vld_o
);

  localparam int unsigned TAP_LO = MIN_CL - 1;
  localparam int unsigned TAP_HI = MAX_CL - 1;

  logic [MAX_CL-1:0] sr_q;

  for (genvar s = 0; s < MAX_CL; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[s] <= 1'b0;
        else        sr_q[s] <= vld_i;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[s] <= 1'b0;
        else        sr_q[s] <= sr_q[s-1];
      end
    end
  end

  assign rd_vld_o = cl3_i ? sr_q[TAP_HI] : sr_q[TAP_LO];

  // R11: two-clock latency
  assert_cl2_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cl3_i |-> (rd_vld_o == $past(vld_i, 2)));

  // R11: three-clock latency
  assert_cl3_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cl3_i |-> (rd_vld_o == $past(vld_i, 3)));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             ilv_i,
  input  logic             cl3_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             err_o,
  output logic             rd_vld_o
);

  logic [COL_W-1:0] mask_w;
  logic             full_w, single_w, vld_w;

  bcs_len_decode #(.COL_W(COL_W)) i_dec (
    .code_i   (blen_i),
    .mask_o   (mask_w),
    .full_o   (full_w),
    .single_o (single_w)
  );

  bcs_addr_gen #(.COL_W(COL_W)) i_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mask_i      (mask_w),
    .full_i      (full_w),
    .single_i    (single_w),
    .ilv_i       (ilv_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .col_vld_o   (vld_w),
    .err_o       (err_o)
  );

  bcs_rd_delay #(.MAX_CL(MAX_CL)) i_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (vld_w),
    .cl3_i    (cl3_i),
    .rd_vld_o (rd_vld_o)
  );

  assign col_vld_o = vld_w;

  // R1: nothing is flagged while the block is in reset
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!vld_w && !err_o);
    end
  end

endmodule

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

  localparam int COL_W = 9;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       blen_i = '0;
  logic             ilv_i = 1'b0;
  logic             cl3_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             col_vld_o, err_o, rd_vld_o;

  burst_col_seq #(.COL_W(COL_W), .MAX_CL(3)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .cl3_i(cl3_i), .stop_i(stop_i),
    .col_o(col_o), .col_vld_o(col_vld_o), .err_o(err_o), .rd_vld_o(rd_vld_o)
  );

  always #5 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  int    exp_q[$];
  string req_q[$];
  bit    h1 = 0, h2 = 0, h3 = 0;

  function automatic int blen_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return ROW;
      default: return 1;
    endcase
  endfunction

  // Expected column of step i, restated with block arithmetic.
  function automatic int exp_col(int col, int len, bit ilv, int i);
    int base, off;
    base = col - (col % len);
    off  = col % len;
    return base + (ilv ? (off ^ i) : ((off + i) % len));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(int n);
    if (n > 0) begin
      repeat (n) @(posedge clk);
      #2;
    end
  endtask

  // Drives a start pulse; returns 2 ns after the sampling edge.
  task automatic issue(int col, int code, bit ilv);
    start_i = 1'b1; start_col_i = COL_W'(col); blen_i = 3'(code); ilv_i = ilv;
    @(posedge clk);
    #2 start_i = 1'b0;
  endtask

  task automatic push(int col, int code, bit ilv, int n, string req);
    int len;
    len = blen_of(code);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_col(col, len, (len == 1) ? 1'b0 : ilv, i));
      req_q.push_back(req);
    end
  endtask

  task automatic run_burst(int col, int code, bit ilv, string req);
    int len;
    len = blen_of(code);
    push(col, code, ilv, len, req);
    issue(col, code, ilv);
    #3 check(col_vld_o === 1'b1 && col_o == COL_W'(col), "R10", int'(col_o), col);
    idle(len + 5);
  endtask

  task automatic run_stopped(int col, int code, int n, string req);
    push(col, code, 1'b0, n, req);
    issue(col, code, 1'b0);
    idle(n - 1);
    stop_i = 1'b1;
    @(posedge clk);
    #2 stop_i = 1'b0;
    #3 check(col_vld_o === 1'b0, "R7", int'(col_vld_o), 0);
    idle(5);
  endtask

  // Monitor: scoreboard pop on each issued column, strobe check against history.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        check(col_vld_o === 1'b0 && err_o === 1'b0 && rd_vld_o === 1'b0, "R1",
              int'({col_vld_o, err_o, rd_vld_o}), 0);
        h1 = 0; h2 = 0; h3 = 0;
      end else begin
        if (col_vld_o) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected column", int'(col_o), -1);
          end else begin
            int    e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(int'(col_o) == e, r, int'(col_o), e);
          end
        end
        if (rd_vld_o || (cl3_i ? h3 : h2))
          check(rd_vld_o == (cl3_i ? h3 : h2), "R11", int'(rd_vld_o), int'(cl3_i ? h3 : h2));
        h3 = h2; h2 = h1; h1 = col_vld_o;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #3 check(col_vld_o === 1'b0 && err_o === 1'b0, "R1", int'(col_vld_o), 0);
    idle(2);

    run_burst(13, 1, 1'b0, "R3 R4 len2");
    run_burst(5,  3, 1'b0, "R4 len8 seq");
    run_burst(45, 3, 1'b1, "R5 len8 xor");
    run_burst(22, 2, 1'b0, "R3 R4 len4 seq");
    run_burst(23, 2, 1'b1, "R5 len4 xor");
    run_burst(301, 3, 1'b0, "R3 len8 high block");
    cl3_i = 1'b1;
    idle(5);
    run_burst(100, 0, 1'b1, "R2 single ignores type");
    run_burst(77,  5, 1'b0, "R12 reserved code");
    run_burst(94,  1, 1'b1, "R5 len2 xor");

    // R6: row burst across the row end, then a whole row and back to start
    run_stopped(510, 7, 5, "R6 row wrap");
    cl3_i = 1'b0;
    idle(5);
    run_stopped(3, 7, ROW + 3, "R6 full row");
    // R7: stop cuts a fixed burst short
    run_stopped(16, 3, 2, "R7 stopped len8");

    // R8: abort a len8 burst after three columns
    push(9, 3, 1'b0, 3, "R8 first burst");
    push(60, 2, 1'b1, 4, "R8 new burst");
    issue(9, 3, 1'b0);
    idle(2);
    issue(60, 2, 1'b1);
    #3 check(col_vld_o === 1'b1 && col_o == COL_W'(60), "R8", int'(col_o), 60);
    idle(8);

    // R8: abort a row burst by a new start
    push(200, 7, 1'b0, 4, "R8 row aborted");
    push(33, 0, 1'b0, 1, "R8 single after row");
    issue(200, 7, 1'b0);
    idle(3);
    issue(33, 0, 1'b0);
    idle(6);

    // R9: rejected row burst, also ending an active burst
    push(40, 3, 1'b0, 2, "R9 burst before reject");
    issue(40, 3, 1'b0);
    idle(1);
    issue(200, 7, 1'b1);
    #3 check(err_o === 1'b1, "R9 flag", int'(err_o), 1);
    check(col_vld_o === 1'b0, "R9 no column", int'(col_vld_o), 0);
    @(negedge clk);
    check(err_o === 1'b0, "R9 one cycle", int'(err_o), 0);
    idle(6);

    check(exp_q.size() == 0, "R7 R8 leftover columns", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule